// File: doc/BRIEF.md
# Drive Fault Supervisor

This block sits between a switching LED controller's fault comparators and its gate driver. It decides, cycle by cycle, whether the driver may switch. Its inputs are debounced fault flags: output short, supply overvoltage, shutdown-pin overvoltage, over-temperature with a separate release flag, die overtemperature with a cool-down flag, and ground-pin loss. It also takes a supply-reset pulse, a power-ok start flag and a static recovery-mode select. It drives one enable and a 3-bit code that names the fault that stopped the drive.

All times are counted in ticks of a slow timebase input, nominally one millisecond. Every duration is a parameter, so a system or bench can shorten them. Some faults must persist for a set time before they act. Over-temperature is ignored for a blanking window after start. Once tripped, a fault ends in one of three ways:
- an off-time followed by a restart;
- a latch that only the supply-reset pulse clears;
- for the die overtemperature fault, a wait for the cool-down flag.

Top module: `fgd_drive_supervisor`

## Requirements
- R1: While reset is held, and after reset until `power_ok` is seen high, `drive_en` is 0 and `fault_code` is 0. One cycle after `power_ok` is sampled high, `drive_en` is 1.
- R2: An output short trips only after `short_in` has been high for `SHORT_TICKS` consecutive ticks. It then sets `fault_code` to 1 and clears `drive_en`.
- R3: Any cycle with `short_in` low restarts the short persistence count from zero.
- R4: A ground-pin fault trips only after `gnd_fault_in` has been high for `GND_TICKS` consecutive ticks. It then sets `fault_code` to 6.
- R5: The immediate faults clear `drive_en` one cycle after they are sampled while running. They are `vcc_ov_in` (code 2), `sd_ov_in` (code 3), `otp_trip_in` (code 4, once blanking is over) and `die_hot_in` (code 5).
- R6: With `latch_mode`=0, a tripped fault keeps `drive_en` at 0 for `OFF_TICKS` ticks, then the block restarts. `fault_code` returns to 0 whenever `drive_en` is 1.
- R7: With `latch_mode`=1, short, ground, SD overvoltage and over-temperature faults hold `drive_en` at 0 indefinitely. A `vcc_reset` pulse returns the block to the off state with code 0, from which it restarts on `power_ok`.
- R8: A supply overvoltage (code 2) always recovers after the off-time, even with `latch_mode`=1.
- R9: `otp_trip_in` is ignored for the first `OTP_BLANK_TICKS` ticks after the block leaves the off state.
- R10: After an over-temperature trip in auto mode, restart waits both for the off-time to end and for `otp_clear_in` to be high.
- R11: A die overtemperature (code 5), in either mode, holds `drive_en` at 0 until `die_cool_in` is high, with no off-time. The block restarts one cycle after `die_cool_in` is sampled high.
- R12: The first fault code is held until restart or `vcc_reset`. When faults arrive together, the priority is die (5) > supply OV (2) > SD OV (3) > OTP (4) > ground (6) > short (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle timebase pulse |
| power_ok | input | 1 | Supply has reached its start level |
| vcc_reset | input | 1 | Supply dropped to reset level; clears latches |
| latch_mode | input | 1 | 1 = latch-off, 0 = auto-recovery |
| short_in | input | 1 | Output short indication |
| vcc_ov_in | input | 1 | Supply overvoltage |
| sd_ov_in | input | 1 | Shutdown-pin overvoltage |
| otp_trip_in | input | 1 | Over-temperature trip level crossed |
| otp_clear_in | input | 1 | Over-temperature release level crossed |
| die_hot_in | input | 1 | Die overtemperature |
| die_cool_in | input | 1 | Die has cooled below its release point |
| gnd_fault_in | input | 1 | Ground-pin loss indication |
| drive_en | output | 1 | Gate drive may switch |
| fault_code | output | 3 | Code of the fault that stopped the drive, 0 if none |

## Verification
Immediate faults, `vcc_reset`, the release flags and `power_ok` act on the first clock edge that samples them. Their effect on `drive_en` and `fault_code` is visible from the next edge on, and the bench reads it at the following falling edge. For timed faults, the count register reaches its limit on the edge that takes the last tick. The state changes one edge later, so the bench's tick task always adds one idle cycle before a check. Each persistence window is tested both one tick short of its limit and at its limit, which pins the trip to an exact tick count.

// File: rtl/fgd_pkg.sv
package fgd_pkg;

  typedef enum logic [2:0] {
    FC_NONE    = 3'd0,
    FC_SHORT   = 3'd1,
    FC_VCC_OV  = 3'd2,
    FC_SD_OV   = 3'd3,
    FC_OTP     = 3'd4,
    FC_DIE_HOT = 3'd5,
    FC_GND     = 3'd6
  } fault_code_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_RUN,
    ST_AUTO,
    ST_LATCH,
    ST_COOL
  } sup_state_e;

endpackage

// File: rtl/fgd_tick_timer.sv
module fgd_tick_timer #(
  parameter int LIMIT = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (tick && (cnt_q != LIM)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == LIM);
endmodule

// File: rtl/fgd_fault_pick.sv
module fgd_fault_pick
  import fgd_pkg::*;
(
  input  logic        die_hit,
  input  logic        vcc_hit,
  input  logic        sd_hit,
  input  logic        otp_hit,
  input  logic        gnd_hit,
  input  logic        short_hit,
  output fault_code_e code,
  output logic        any
);
  always_comb begin
    if      (die_hit)   code = FC_DIE_HOT;
    else if (vcc_hit)   code = FC_VCC_OV;
    else if (sd_hit)    code = FC_SD_OV;
    else if (otp_hit)   code = FC_OTP;
    else if (gnd_hit)   code = FC_GND;
    else if (short_hit) code = FC_SHORT;
    else                code = FC_NONE;
  end

  assign any = (code != FC_NONE);
endmodule

// File: rtl/fgd_drive_supervisor.sv
module fgd_drive_supervisor
  import fgd_pkg::*;
#(
  parameter int SHORT_TICKS     = 90,
  parameter int GND_TICKS       = 200,
  parameter int OTP_BLANK_TICKS = 250,
  parameter int OFF_TICKS       = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       power_ok,
  input  logic       vcc_reset,
  input  logic       latch_mode,
  input  logic       short_in,
  input  logic       vcc_ov_in,
  input  logic       sd_ov_in,
  input  logic       otp_trip_in,
  input  logic       otp_clear_in,
  input  logic       die_hot_in,
  input  logic       die_cool_in,
  input  logic       gnd_fault_in,
  output logic       drive_en,
  output logic [2:0] fault_code
);
  // reset: asserted asynchronously, released through two flops
  logic rst_meta_n, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_int_n  <= rst_meta_n;
    end
  end

  sup_state_e  state_q, state_d;
  fault_code_e code_q, code_d;
  fault_code_e pick_code;
  logic        pick_any;
  logic        short_done, gnd_done, blank_done, off_done;
  logic        running;

  assign running = (state_q == ST_RUN);

  fgd_tick_timer #(.LIMIT(SHORT_TICKS)) u_short_tmr (
    .clk(clk), .rst_n(rst_int_n), .clr(!short_in || !running),
    .tick(tick), .done(short_done));

  fgd_tick_timer #(.LIMIT(GND_TICKS)) u_gnd_tmr (
    .clk(clk), .rst_n(rst_int_n), .clr(!gnd_fault_in || !running),
    .tick(tick), .done(gnd_done));

  fgd_tick_timer #(.LIMIT(OTP_BLANK_TICKS)) u_blank_tmr (
    .clk(clk), .rst_n(rst_int_n), .clr(state_q == ST_OFF),
    .tick(tick), .done(blank_done));

  fgd_tick_timer #(.LIMIT(OFF_TICKS)) u_off_tmr (
    .clk(clk), .rst_n(rst_int_n), .clr(state_q != ST_AUTO),
    .tick(tick), .done(off_done));

  fgd_fault_pick u_pick (
    .die_hit  (die_hot_in),
    .vcc_hit  (vcc_ov_in),
    .sd_hit   (sd_ov_in),
    .otp_hit  (otp_trip_in && blank_done),
    .gnd_hit  (gnd_fault_in && gnd_done),
    .short_hit(short_in && short_done),
    .code     (pick_code),
    .any      (pick_any));

  // next-state logic
  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    if (vcc_reset) begin
      state_d = ST_OFF;
      code_d  = FC_NONE;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (power_ok) state_d = ST_RUN;
        end
        ST_RUN: begin
          if (pick_any) begin
            code_d = pick_code;
            if (pick_code == FC_DIE_HOT)                    state_d = ST_COOL;
            else if (pick_code == FC_VCC_OV || !latch_mode) state_d = ST_AUTO;
            else                                            state_d = ST_LATCH;
          end
        end
        ST_AUTO: begin
          if (off_done && (code_q != FC_OTP || otp_clear_in)) begin
            state_d = ST_RUN;
            code_d  = FC_NONE;
          end
        end
        ST_COOL: begin
          if (die_cool_in) begin
            state_d = ST_RUN;
            code_d  = FC_NONE;
          end
        end
        ST_LATCH: state_d = ST_LATCH;
        default: begin
          state_d = ST_OFF;
          code_d  = FC_NONE;
        end
      endcase
    end
  end

  // state registers, written only when something changes
  logic upd_en;
  assign upd_en = (state_d != state_q) || (code_d != code_q);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_OFF;
      code_q  <= FC_NONE;
    end else if (upd_en) begin
      state_q <= state_d;
      code_q  <= code_d;
    end
  end

  assign drive_en   = running;
  assign fault_code = code_q;
endmodule

// File: rtl/fgd_supervisor_chk.sv
module fgd_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vcc_reset,
  input logic       latch_mode,
  input logic       vcc_ov_in,
  input logic       die_cool_in,
  input logic       drive_en,
  input logic [2:0] fault_code
);
  AST_RUN_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> (fault_code == 3'd0)); // R6

  AST_VCC_OV_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && vcc_ov_in && !vcc_reset) |=> !drive_en); // R5

  AST_VCC_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_reset |=> (fault_code == 3'd0 && !drive_en)); // R7

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && fault_code == 3'd3 && !vcc_reset) |=> !drive_en); // R7

  AST_DIE_WAITS_COOL: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code == 3'd5 && !die_cool_in && !vcc_reset) |=> !drive_en); // R11

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != 3'd0 && !vcc_reset) |=>
      (fault_code == $past(fault_code) || fault_code == 3'd0)); // R12
endmodule

bind fgd_drive_supervisor fgd_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vcc_reset(vcc_reset), .latch_mode(latch_mode),
  .vcc_ov_in(vcc_ov_in), .die_cool_in(die_cool_in),
  .drive_en(drive_en), .fault_code(fault_code));

// File: tb/fgd_drive_supervisor_bench.sv
module fgd_drive_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT_T = 3;
  localparam int GND_T   = 5;
  localparam int BLANK_T = 4;
  localparam int OFF_T   = 6;

  // row: [6:5] fault select (0 vcc_ov, 1 sd_ov, 2 otp, 3 die), [4] latch_mode,
  //      [3:1] expected code, [0] expected restart after off-time with releases high
  localparam logic [6:0] VEC [8] = '{
    {2'd0, 1'b0, 3'd2, 1'b1},
    {2'd0, 1'b1, 3'd2, 1'b1},
    {2'd1, 1'b0, 3'd3, 1'b1},
    {2'd1, 1'b1, 3'd3, 1'b0},
    {2'd2, 1'b0, 3'd4, 1'b1},
    {2'd2, 1'b1, 3'd4, 1'b0},
    {2'd3, 1'b0, 3'd5, 1'b1},
    {2'd3, 1'b1, 3'd5, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, tick, power_ok, vcc_reset, latch_mode;
  logic short_in, vcc_ov_in, sd_ov_in, otp_trip_in, otp_clear_in;
  logic die_hot_in, die_cool_in, gnd_fault_in;
  logic drive_en;
  logic [2:0] fault_code;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fgd_drive_supervisor #(
    .SHORT_TICKS(SHORT_T), .GND_TICKS(GND_T),
    .OTP_BLANK_TICKS(BLANK_T), .OFF_TICKS(OFF_T)
  ) u_fgd_drive_supervisor (
    .clk(clk), .rst_n(rst_n), .tick(tick), .power_ok(power_ok),
    .vcc_reset(vcc_reset), .latch_mode(latch_mode), .short_in(short_in),
    .vcc_ov_in(vcc_ov_in), .sd_ov_in(sd_ov_in), .otp_trip_in(otp_trip_in),
    .otp_clear_in(otp_clear_in), .die_hot_in(die_hot_in),
    .die_cool_in(die_cool_in), .gnd_fault_in(gnd_fault_in),
    .drive_en(drive_en), .fault_code(fault_code));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // n tick pulses, then one idle cycle so the state step after the last count is visible
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic clear_faults();
    short_in = 0; vcc_ov_in = 0; sd_ov_in = 0; otp_trip_in = 0;
    otp_clear_in = 0; die_hot_in = 0; die_cool_in = 0; gnd_fault_in = 0;
  endtask

  task automatic pulse_vcc_reset();
    @(negedge clk) vcc_reset = 1'b1;
    @(negedge clk) vcc_reset = 1'b0;
  endtask

  task automatic restart(input logic mode);
    clear_faults();
    latch_mode = mode;
    pulse_vcc_reset();
    idle(1);
    ticks(BLANK_T);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; tick = 0; power_ok = 0; vcc_reset = 0; latch_mode = 0;
    clear_faults();
    idle(3);
    chk("R1 drive in reset", int'(drive_en), 0);
    chk("R1 code in reset", int'(fault_code), 0);
    rst_n = 1;
    idle(5);
    chk("R1 no drive before power_ok", int'(drive_en), 0);
    power_ok = 1;
    idle(2);
    chk("R1 drive after power_ok", int'(drive_en), 1);

    // table of immediate-fault scenarios
    for (int r = 0; r < 8; r++) begin
      restart(VEC[r][4]);
      chk("R5 running before fault", int'(drive_en), 1);
      @(negedge clk);
      case (VEC[r][6:5])
        2'd0: vcc_ov_in = 1;
        2'd1: sd_ov_in = 1;
        2'd2: otp_trip_in = 1;
        default: die_hot_in = 1;
      endcase
      idle(1);
      chk("R5 drive off after fault", int'(drive_en), 0);
      chk("R5 fault code", int'(fault_code), int'(VEC[r][3:1]));
      clear_faults();
      otp_clear_in = 1; die_cool_in = 1;
      ticks(OFF_T);
      idle(1);
      chk("R6 R7 R8 R11 restart by mode", int'(drive_en), int'(VEC[r][0]));
      otp_clear_in = 0; die_cool_in = 0;
      if (!VEC[r][0]) begin
        pulse_vcc_reset();
        chk("R7 latch cleared by vcc_reset", int'(fault_code), 0);
      end
    end

    // short persistence and break
    restart(0);
    short_in = 1;
    ticks(SHORT_T - 1);
    chk("R2 short below limit", int'(drive_en), 1);
    short_in = 0;
    idle(1);
    short_in = 1;
    ticks(SHORT_T - 1);
    chk("R3 break restarts count", int'(drive_en), 1);
    ticks(1);
    chk("R2 short trips", int'(drive_en), 0);
    chk("R2 short code", int'(fault_code), 1);
    short_in = 0;
    ticks(OFF_T - 1);
    chk("R6 still off before off-time", int'(drive_en), 0);
    ticks(1);
    chk("R6 restart after off-time", int'(drive_en), 1);
    chk("R6 code cleared on restart", int'(fault_code), 0);

    // ground fault with latch
    restart(1);
    gnd_fault_in = 1;
    ticks(GND_T - 1);
    chk("R4 ground below limit", int'(drive_en), 1);
    ticks(1);
    chk("R4 ground trips", int'(drive_en), 0);
    chk("R4 ground code", int'(fault_code), 6);
    gnd_fault_in = 0;
    ticks(OFF_T + 2);
    chk("R7 latch holds drive off", int'(drive_en), 0);
    chk("R7 latch holds code", int'(fault_code), 6);
    pulse_vcc_reset();
    chk("R7 vcc_reset clears code", int'(fault_code), 0);
    idle(1);
    chk("R7 restart after vcc_reset", int'(drive_en), 1);

    // over-temperature blanking and release
    clear_faults();
    latch_mode = 0;
    otp_trip_in = 1;
    pulse_vcc_reset();
    idle(1);
    ticks(BLANK_T - 1);
    chk("R9 otp ignored during blanking", int'(drive_en), 1);
    ticks(1);
    chk("R9 otp trips after blanking", int'(drive_en), 0);
    chk("R9 otp code", int'(fault_code), 4);
    otp_trip_in = 0;
    ticks(OFF_T + 1);
    chk("R10 waits for release", int'(drive_en), 0);
    otp_clear_in = 1;
    idle(1);
    chk("R10 restart on release", int'(drive_en), 1);
    otp_clear_in = 0;

    // priority and hold
    restart(0);
    vcc_ov_in = 1; sd_ov_in = 1;
    idle(1);
    chk("R12 priority supply over SD", int'(fault_code), 2);
    die_hot_in = 1;
    idle(2);
    chk("R12 first code held", int'(fault_code), 2);
    clear_faults();

    // die overtemperature ignores off-time
    restart(0);
    die_hot_in = 1;
    idle(1);
    die_hot_in = 0;
    ticks(OFF_T + 2);
    chk("R11 waits for cool", int'(drive_en), 0);
    chk("R11 die code", int'(fault_code), 5);
    die_cool_in = 1;
    idle(1);
    chk("R11 restart on cool", int'(drive_en), 1);
    die_cool_in = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule